// File: doc/BRIEF.md
# Multiprocessor-Capable Asynchronous Serial Port

This block is a full-duplex asynchronous serial port. A processor reaches it through a two-address register port. Address 0 holds an 8-bit control and status word. Address 1 is a shared data address: a write there hands a byte to the transmitter, and a read returns the last byte the receiver accepted. The bit rate is set outside the block. The transmitter and the receiver each take their own tick input, and each tick pulses at sixteen times the bit rate. One interrupt line is high whenever the transmit-done flag or the receive-done flag is set.

The port sends and receives frames with 8 data bits, or frames with 9 data bits in which the ninth bit marks an address. For a multiprocessor link, a filter bit makes the receiver drop frames: in 9-bit modes it drops a frame whose ninth bit is 0, and in 8-bit mode it drops a frame whose stop bit is bad. A slave therefore wakes only on address frames. The receiver uses a shift register and a separate holding buffer, so a new frame can arrive while the previous byte is still unread. The register port is a plain strobe interface with no back-pressure: a write always takes effect in the cycle it is strobed, and a read returns its value in the same cycle.

Top module: `uart_mp_core`

## Requirements
- R1: After reset the control word reads 0x00, the data address reads 0x00, `txd` is 1 and `irq` is 0.
- R2: A write to address 1 while the transmitter is idle sends a frame on `txd`, LSB first. The frame is one start bit (0), 8 data bits, then a ninth bit equal to control bit 3 (TB8) when control bits 7:6 are 10 or 11, then one stop bit (1). Each bit lasts 16 `tx_tick16` pulses. Codes 00 and 01 send no ninth bit. The line idles at 1.
- R3: Control bit 1 (TI) is set at the end of the stop bit and stays set until a control write clears it.
- R4: A write to address 1 while a frame is being sent is ignored. The frame in flight is unchanged and no second frame follows.
- R5: Reception takes place only while control bit 4 (REN) is 1. A frame that arrives while REN is 0 leaves control bit 0 (RI) and the receive buffer unchanged.
- R6: When the receiver accepts a frame, it loads the buffer (read at address 1) and sets RI. It also loads control bit 2 (RB8): in 9-bit modes with the received ninth bit, and in 8-bit modes with the received stop bit.
- R7: In 9-bit modes with control bit 5 (SM2) set, a frame whose ninth bit is 0 leaves RI, RB8 and the buffer unchanged.
- R8: In 8-bit modes with SM2 set, a frame whose stop bit samples as 0 leaves RI, RB8 and the buffer unchanged.
- R9: A frame accepted while RI is still set overwrites the buffer. The earlier byte is lost and RI stays 1.
- R10: A low pulse on `rxd` that is shorter than half a bit does not start a reception. The receiver decides each bit by a majority of three samples at ticks 7, 8 and 9 of the bit.
- R11: `irq` equals TI OR RI in every cycle.
- R12: A write to address 0 replaces all 8 control bits. Software can therefore set or clear TI and RI. If hardware sets a flag in the same cycle as the write, the hardware set takes priority.
- R13: Transmission and reception run at the same time. With `txd` looped back to `rxd`, the byte being sent is received as it goes out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 1 | 0 selects the control word, 1 selects the data address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tx_tick16 | input | 1 | Transmit tick, 16 per bit |
| rx_tick16 | input | 1 | Receive tick, 16 per bit |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input, asynchronous |
| irq | output | 1 | TI OR RI |

## Verification
The assertions rely on `tx_tick16` and `rx_tick16` being single-cycle pulses. They also rely on software not reprogramming the mode or the filter bit while a frame is in flight, because the receiver reads those bits live. The bench keeps to both rules: it makes each tick one clock wide every second cycle, and it writes the control word only while both serial paths are idle. The bench drives `rxd` with whole bit times of 32 clocks. The only exception is a deliberately short low pulse used to test start-bit rejection, so the centre samples of each bit never fall on a transition.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;

  localparam int unsigned CTL_W   = 8;
  localparam int unsigned BYTE_W  = 8;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  localparam int unsigned CB_RI   = 0;
  localparam int unsigned CB_TI   = 1;
  localparam int unsigned CB_RB8  = 2;
  localparam int unsigned CB_TB8  = 3;
  localparam int unsigned CB_REN  = 4;
  localparam int unsigned CB_SM2  = 5;
  localparam int unsigned CB_MLO  = 6;
  localparam int unsigned CB_MHI  = 7;

  typedef enum logic {
    RX_IDLE   = 1'b0,
    RX_ACTIVE = 1'b1
  } rx_state_t;

  function automatic logic mode_is_nine(input logic [1:0] mode);
    return mode[1];
  endfunction

endpackage

// File: rtl/uart_mp_tx.sv
module uart_mp_tx #(
  parameter int unsigned OVS    = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              nine_i,
  input  logic              b9_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int unsigned PW     = $clog2(OVS);
  localparam int unsigned FRM_W  = BYTE_W + 3;
  localparam int unsigned CNT_W  = $clog2(FRM_W + 1);

  logic [FRM_W-1:0] shreg;
  logic [PW-1:0]    phase;
  logic [CNT_W-1:0] bits_left;
  logic             busy_q;
  logic             bit_end;

  assign bit_end = busy_q && tick_i && (phase == PW'(OVS - 1));
  assign done_o  = bit_end && (bits_left == CNT_W'(1));
  assign txd_o   = shreg[0];
  assign busy_o  = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '1;
      phase     <= '0;
      bits_left <= '0;
      busy_q    <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        shreg     <= {1'b1, (nine_i ? b9_i : 1'b1), data_i, 1'b0};
        bits_left <= nine_i ? CNT_W'(BYTE_W + 3) : CNT_W'(BYTE_W + 2);
        phase     <= '0;
        busy_q    <= 1'b1;
      end
    end else if (tick_i) begin
      phase <= phase + 1'b1;
      if (bit_end) begin
        shreg     <= {1'b1, shreg[FRM_W-1:1]};
        bits_left <= bits_left - 1'b1;
        if (bits_left == CNT_W'(1)) busy_q <= 1'b0;
      end
    end
  end

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd_o) else $error("idle line low"); // R2

  AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> txd_o) else $error("stop bit low"); // R2

  AST_TX_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !tick_i) |=> $stable(shreg)) else $error("load while busy"); // R4

endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
  import uart_mp_pkg::*;
#(
  parameter int unsigned OVS    = 16,
  parameter int unsigned SYNC   = 2,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              nine_i,
  input  logic              line_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              bit9_o,
  output logic              stop_o
);

  localparam int unsigned PW    = $clog2(OVS);
  localparam int unsigned MID   = OVS / 2;
  localparam int unsigned SMP_A = MID - 1;
  localparam int unsigned SMP_C = MID + 1;
  localparam int unsigned IW    = $clog2(BYTE_W + 3);

  logic [SYNC-1:0] sync_q;
  logic            line_s;
  logic            last_q;
  rx_state_t       state;
  logic [PW-1:0]   phase;
  logic [IW-1:0]   idx;
  logic            smp_a, smp_b, maj;
  logic [BYTE_W-1:0] shreg;
  logic            bit9_q;

  assign line_s = sync_q[SYNC-1];
  assign maj    = (smp_a & smp_b) | (smp_a & line_s) | (smp_b & line_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], line_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b1;
      state  <= RX_IDLE;
      phase  <= '0;
      idx    <= '0;
      smp_a  <= 1'b1;
      smp_b  <= 1'b1;
      shreg  <= '0;
      bit9_q <= 1'b0;
      done_o <= 1'b0;
      data_o <= '0;
      bit9_o <= 1'b0;
      stop_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) last_q <= line_s;
      if (!en_i) begin
        state <= RX_IDLE;
      end else if (tick_i) begin
        case (state)
          RX_IDLE: begin
            if (last_q && !line_s) begin
              state <= RX_ACTIVE;
              phase <= '0;
              idx   <= '0;
            end
          end
          RX_ACTIVE: begin
            phase <= phase + 1'b1;
            if (phase == PW'(SMP_A)) smp_a <= line_s;
            if (phase == PW'(MID))   smp_b <= line_s;
            if (phase == PW'(SMP_C)) begin
              idx <= idx + 1'b1;
              if (idx == '0) begin
                if (maj) state <= RX_IDLE;
              end else if (idx <= IW'(BYTE_W)) begin
                shreg <= {maj, shreg[BYTE_W-1:1]};
              end else if (nine_i && idx == IW'(BYTE_W + 1)) begin
                bit9_q <= maj;
              end else begin
                stop_o <= maj;
                data_o <= shreg;
                bit9_o <= bit9_q;
                done_o <= 1'b1;
                state  <= RX_IDLE;
              end
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  AST_RX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (state == RX_IDLE)) else $error("rx active while disabled"); // R5

  AST_RX_DONE_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(state) == RX_ACTIVE && $past(en_i))) else $error("done without frame"); // R6

endmodule

// File: rtl/uart_mp_core.sv
module uart_mp_core
  import uart_mp_pkg::*;
#(
  parameter int unsigned OVS  = 16,
  parameter int unsigned SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic [CTL_W-1:0]  reg_wdata,
  output logic [CTL_W-1:0]  reg_rdata,
  input  logic              tx_tick16,
  input  logic              rx_tick16,
  output logic              txd,
  input  logic              rxd,
  output logic              irq
);

  logic [1:0]        mode_q;
  logic              sm2_q, ren_q, tb8_q, rb8_q, ti_q, ri_q;
  logic [BYTE_W-1:0] rbuf_q;
  logic [CTL_W-1:0]  ctrl_word;
  logic              ctrl_wr, data_wr, nine;
  logic              tx_busy, tx_done;
  logic              rx_done, rx_bit9, rx_stop, rx_accept, rx_rb8;
  logic [BYTE_W-1:0] rx_data;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign data_wr = reg_wr && (reg_addr == ADDR_DATA);
  assign nine    = mode_is_nine(mode_q);

  assign ctrl_word = {mode_q, sm2_q, ren_q, tb8_q, rb8_q, ti_q, ri_q};
  assign reg_rdata = (reg_addr == ADDR_DATA) ? rbuf_q : ctrl_word;
  assign irq       = ti_q | ri_q;

  assign rx_rb8    = nine ? rx_bit9 : rx_stop;
  assign rx_accept = rx_done && (!sm2_q || rx_rb8);

  uart_mp_tx #(.OVS(OVS), .BYTE_W(BYTE_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tx_tick16),
    .start_i (data_wr),
    .data_i  (reg_wdata),
    .nine_i  (nine),
    .b9_i    (tb8_q),
    .txd_o   (txd),
    .busy_o  (tx_busy),
    .done_o  (tx_done)
  );

  uart_mp_rx #(.OVS(OVS), .SYNC(SYNC), .BYTE_W(BYTE_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (rx_tick16),
    .en_i    (ren_q),
    .nine_i  (nine),
    .line_i  (rxd),
    .done_o  (rx_done),
    .data_o  (rx_data),
    .bit9_o  (rx_bit9),
    .stop_o  (rx_stop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      sm2_q  <= 1'b0;
      ren_q  <= 1'b0;
      tb8_q  <= 1'b0;
      rb8_q  <= 1'b0;
      ti_q   <= 1'b0;
      ri_q   <= 1'b0;
      rbuf_q <= '0;
    end else begin
      if (ctrl_wr) begin
        mode_q <= reg_wdata[CB_MHI:CB_MLO];
        sm2_q  <= reg_wdata[CB_SM2];
        ren_q  <= reg_wdata[CB_REN];
        tb8_q  <= reg_wdata[CB_TB8];
        rb8_q  <= reg_wdata[CB_RB8];
        ti_q   <= reg_wdata[CB_TI];
        ri_q   <= reg_wdata[CB_RI];
      end
      if (tx_done) ti_q <= 1'b1;
      if (rx_accept) begin
        rbuf_q <= rx_data;
        rb8_q  <= rx_rb8;
        ri_q   <= 1'b1;
      end
    end
  end

  AST_TI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti_q) |-> ($past(tx_done) || $past(ctrl_wr && reg_wdata[CB_TI]))) else $error("TI spurious"); // R3

  AST_RI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri_q) |-> ($past(rx_done) || $past(ctrl_wr && reg_wdata[CB_RI]))) else $error("RI spurious"); // R6

  AST_ADDR_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && nine && sm2_q && !rx_bit9 && !ctrl_wr) |=> ($stable(ri_q) && $stable(rbuf_q))) else $error("filter leak"); // R7

  AST_STOP_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !nine && sm2_q && !rx_stop && !ctrl_wr) |=> ($stable(ri_q) && $stable(rbuf_q))) else $error("stop filter leak"); // R8

  AST_TX_FLAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> ti_q) else $error("TI lost"); // R12

endmodule

// File: tb/test_uart_mp_core.sv
module test_uart_mp_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_addr = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tick = 1'b0;
  logic       txd;
  logic       rx_drv = 1'b1;
  logic       loop_en = 1'b0;
  logic       rxd;
  logic       irq;

  int errors = 0;
  int checks = 0;
  logic [7:0] rbuf_exp = 8'h00;

  always #2.5 clk = ~clk;

  assign rxd = loop_en ? txd : rx_drv;

  always_ff @(posedge clk) tick <= ~tick;

  uart_mp_core i_uart_mp_core (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_tick16(tick),
    .rx_tick16(tick), .txd(txd), .rxd(rxd), .irq(irq)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic bit_time(input logic v);
    rx_drv = v; repeat (32) @(negedge clk);
  endtask

  task automatic rx_send(input logic [7:0] d, input logic has9, input logic b9, input logic st);
    @(negedge clk);
    bit_time(1'b0);
    for (int i = 0; i < 8; i++) bit_time(d[i]);
    if (has9) bit_time(b9);
    bit_time(st);
    bit_time(1'b1);
    bit_time(1'b1);
  endtask

  task automatic tx_cap(input logic has9, output logic s0, output logic [7:0] d,
                        output logic b9, output logic st);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    repeat (15) @(negedge clk);
    s0 = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (32) @(negedge clk); d[i] = txd;
    end
    b9 = 1'b1;
    if (has9) begin repeat (32) @(negedge clk); b9 = txd; end
    repeat (32) @(negedge clk); st = txd;
  endtask

  initial begin
    logic [7:0] v, d;
    logic s0, b9, st;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, v); chk("R1 ctrl", v, 8'h00);
    rd(1'b1, v); chk("R1 data", v, 8'h00);
    chk("R1 txd", {7'd0, txd}, 8'h01);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R12 and R11: full software write and readback
    wr(1'b0, 8'hFF); rd(1'b0, v); chk("R12 write all", v, 8'hFF);
    chk("R11 irq both", {7'd0, irq}, 8'h01);
    wr(1'b0, 8'h02); chk("R11 irq ti", {7'd0, irq}, 8'h01);
    wr(1'b0, 8'h00); rd(1'b0, v); chk("R12 clear", v, 8'h00);
    chk("R11 irq none", {7'd0, irq}, 8'h00);

    // R2 R3 R6 R13: loopback sweep over modes and TB8
    loop_en = 1'b1;
    for (int m = 0; m < 4; m++) begin
      for (int t = 0; t < 2; t++) begin
        logic nine;
        logic [7:0] ctl;
        nine = (m >= 2);
        d = 8'(8'h3C ^ (m * 53 + t * 17));
        ctl = {m[1:0], 1'b0, 1'b1, t[0], 3'b000};
        wr(1'b0, ctl);
        fork
          tx_cap(nine, s0, v, b9, st);
          wr(1'b1, d);
        join
        chk("R2 start", {7'd0, s0}, 8'h00);
        chk("R2 data", v, d);
        chk("R2 ninth", {7'd0, b9}, nine ? {7'd0, t[0]} : 8'h01);
        chk("R2 stop", {7'd0, st}, 8'h01);
        repeat (40) @(negedge clk);
        rd(1'b0, v);
        chk("R3 TI set", {7'd0, v[1]}, 8'h01);
        chk("R13 RI set", {7'd0, v[0]}, 8'h01);
        chk("R6 RB8 loop", {7'd0, v[2]}, nine ? {7'd0, t[0]} : 8'h01);
        rd(1'b1, v); chk("R13 loop byte", v, d);
        chk("R11 irq", {7'd0, irq}, 8'h01);
        rbuf_exp = d;
      end
    end
    wr(1'b0, 8'h50); rd(1'b0, v); chk("R3 TI cleared", {7'd0, v[1]}, 8'h00);

    // R4: write during transmission ignored
    loop_en = 1'b0;
    fork
      tx_cap(1'b0, s0, v, b9, st);
      begin wr(1'b1, 8'hA5); repeat (100) @(negedge clk); wr(1'b1, 8'h0F); end
    join
    chk("R4 frame kept", v, 8'hA5);
    repeat (40) @(negedge clk);
    wr(1'b0, 8'h50);
    begin
      int lows = 0;
      for (int i = 0; i < 400; i++) begin @(negedge clk); if (txd == 1'b0) lows++; end
      chk("R4 no second frame", 8'(lows), 8'h00);
    end
    rd(1'b0, v); chk("R4 TI stays clear", {7'd0, v[1]}, 8'h00);

    // R5: REN off
    wr(1'b0, 8'h40);
    rx_send(8'h99, 1'b0, 1'b0, 1'b1);
    rd(1'b0, v); chk("R5 RI", {7'd0, v[0]}, 8'h00);
    rd(1'b1, v); chk("R5 buffer", v, rbuf_exp);

    // R6 R7 R8: filter sweep over mode, SM2, ninth bit, stop bit
    for (int m = 1; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int b = 0; b < 2; b++) begin
          for (int p = 0; p < 2; p++) begin
            logic nine, acc, rb;
            nine = (m >= 2);
            rb   = nine ? b[0] : p[0];
            acc  = !s[0] || rb;
            d    = 8'(8'h5A ^ (m * 37 + s * 11 + b * 5 + p * 3));
            wr(1'b0, {m[1:0], s[0], 1'b1, 4'b0000});
            rx_send(d, nine, b[0], p[0]);
            if (acc) rbuf_exp = d;
            rd(1'b0, v);
            chk(nine ? "R7 RI" : "R8 RI", {7'd0, v[0]}, {7'd0, acc});
            chk("R6 RB8", {7'd0, v[2]}, acc ? {7'd0, rb} : 8'h00);
            rd(1'b1, v);
            chk(nine ? "R7 buffer" : "R8 buffer", v, rbuf_exp);
          end
        end
      end
    end

    // R9: overrun
    wr(1'b0, 8'h50);
    rx_send(8'h11, 1'b0, 1'b0, 1'b1);
    rx_send(8'h22, 1'b0, 1'b0, 1'b1);
    rd(1'b1, v); chk("R9 overwrite", v, 8'h22);
    rd(1'b0, v); chk("R9 RI", {7'd0, v[0]}, 8'h01);

    // R10: glitch rejected, then a real frame still lands
    wr(1'b0, 8'h50);
    @(negedge clk); rx_drv = 1'b0; repeat (8) @(negedge clk); rx_drv = 1'b1;
    repeat (400) @(negedge clk);
    rd(1'b0, v); chk("R10 glitch RI", {7'd0, v[0]}, 8'h00);
    rx_send(8'hC3, 1'b0, 1'b0, 1'b1);
    rd(1'b1, v); chk("R10 frame after glitch", v, 8'hC3);

    summary();
    $finish;
  end

endmodule